// File: doc/BRIEF.md
# Periodic Down-Counter Timer

This block is a 32-bit timer on a small word-addressed register bus. Software loads a period and starts the counter. The counter then decrements once per clock. When it reaches zero the block records a timeout. In one-shot mode the counter then halts. In auto-reload mode it refills itself from the stored period and keeps going.

A level interrupt combines the timeout flag with an enable bit. Software acknowledges the interrupt by writing to the status word. The live count can be sampled at any time through a read-only snapshot word.

Four words are decoded from byte address bits [3:2], and bits [1:0] are ignored:
- 0x0 is status.
- 0x4 is control.
- 0x8 is period.
- 0xC is snapshot.

Any address with a bit set above bit 3 is unmapped.

Top module: `dcount_timer`

## Requirements
- R1: After reset, every register word (status, control, period, snapshot) reads zero, the interrupt is low and the counter is stopped.
- R2: A write to status (0x0) clears the timeout flag (status bit 0) whatever the data written. No other status bit is writable. If an expiry falls in the same cycle as that write, the flag stays set.
- R3: A write to control (0x4) stores the full word, which reads back unchanged. Control bit 2 starts the counter and control bit 3 stops it. When both are set in one write, the counter stops.
- R4: A write to period (0x8) stores the word, and the live counter holds that value from the next cycle on, even while running.
- R5: A read of snapshot (0xC) returns the live counter. Writes to 0xC change nothing.
- R6: While running, the counter drops by one per clock. With period N, the count reaches 0 after N ticks and expiry happens on tick N+1. A period of 0 therefore expires on the first tick after start.
- R7: With control bit 1 clear (one-shot), expiry sets the timeout flag and stops the counter at 0. Status bit 1 (running) then reads 0.
- R8: With control bit 1 set (auto-reload), expiry sets the timeout flag, reloads the counter from period, and leaves it running.
- R9: The interrupt output is high exactly when the timeout flag and control bit 0 are both set. It follows each register write and each expiry from the next cycle.
- R10: Addresses with any bit set above bit 3 read as zero and ignore writes. Byte address bits [1:0] have no effect on which word is selected.
- R11: Status reads the timeout flag in bit 0 and the running state in bit 1, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter ticks on each rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| rd_en | input | 1 | Read strobe; read data is zero when low |
| addr | input | 5 | Byte address of the word accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from the current state |
| irq | output | 1 | Level interrupt: timeout flag AND enable |

## Verification
The table-driven part runs one-shot counts over several periods, including zero, with waits:
- shorter than the period;
- equal to the period;
- one short of the period;
- well past expiry.

This separates an off-by-one in the decrement from an off-by-one in the expiry cycle. Directed sequences then cover:
- auto-reload against one-shot;
- a period write landing in a running count;
- a stop and start in the same control word;
- a status write in the exact cycle of an expiry.

Each of these distinguishes a priority order that a wrong design would flip. The interrupt is toggled separately through its enable bit and through the acknowledge, and unmapped and aliased addresses are probed to show the decode.

// File: rtl/dcount_timer_pkg.sv
package dcount_timer_pkg;
  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_PER  = 2'd2,
    SEL_SNAP = 2'd3
  } word_sel_e;

  localparam int CTL_IE   = 0;
  localparam int CTL_AUTO = 1;
  localparam int CTL_GO   = 2;
  localparam int CTL_HALT = 3;

  localparam int ST_TO  = 0;
  localparam int ST_RUN = 1;
endpackage

// File: rtl/dcount_timer_decode.sv
module dcount_timer_decode
  import dcount_timer_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:2] word_addr,
  output logic              wr_stat,
  output logic              wr_ctrl,
  output logic              wr_per,
  output logic              rd_hit,
  output word_sel_e         sel
);
  logic mapped;

  generate
    if (ADDR_W > 4) begin : g_upper
      assign mapped = (word_addr[ADDR_W-1:4] == '0);
    end else begin : g_flat
      assign mapped = 1'b1;
    end
  endgenerate

  assign sel     = word_sel_e'(word_addr[3:2]);
  assign wr_stat = wr_en && mapped && (sel == SEL_STAT);
  assign wr_ctrl = wr_en && mapped && (sel == SEL_CTRL);
  assign wr_per  = wr_en && mapped && (sel == SEL_PER);
  assign rd_hit  = rd_en && mapped;
endmodule

// File: rtl/dcount_timer_regs.sv
module dcount_timer_regs
  import dcount_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stat,
  input  logic              wr_ctrl,
  input  logic              wr_per,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] period_q,
  output logic              timeout,
  output logic              irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      period_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q   <= wdata;
      if (wr_per)  period_q <= wdata;
    end
  end

  // expiry takes precedence over an acknowledge in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       timeout <= 1'b0;
    else if (expire)  timeout <= 1'b1;
    else if (wr_stat) timeout <= 1'b0;
  end

  assign irq = timeout & ctrl_q[CTL_IE];
endmodule

// File: rtl/dcount_timer_counter.sv
module dcount_timer_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [DATA_W-1:0] ld_val,
  input  logic              go,
  input  logic              halt,
  input  logic              auto_reload,
  input  logic [DATA_W-1:0] period,
  output logic [DATA_W-1:0] count,
  output logic              running,
  output logic              expire
);
  function automatic logic [DATA_W-1:0] step_down(input logic [DATA_W-1:0] v);
    return v - {{(DATA_W-1){1'b0}}, 1'b1};
  endfunction

  logic at_zero;
  logic tick_dec;

  assign at_zero  = (count == '0);
  assign expire   = running && at_zero;
  assign tick_dec = running && !at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    count <= '0;
    else if (ld_en)                count <= ld_val;
    else if (expire && auto_reload) count <= period;
    else if (tick_dec)             count <= step_down(count);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      running <= 1'b0;
    else if (halt)                   running <= 1'b0;
    else if (go)                     running <= 1'b1;
    else if (expire && !auto_reload) running <= 1'b0;
  end
endmodule

// File: rtl/dcount_timer.sv
module dcount_timer
  import dcount_timer_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic              wr_stat, wr_ctrl, wr_per, rd_hit;
  word_sel_e         sel;
  logic [DATA_W-1:0] ctrl_q, period_q, count;
  logic              timeout, running, expire;
  logic [DATA_W-1:0] stat_word;
  logic              unused_byte_lane;

  assign unused_byte_lane = ^addr[1:0];

  dcount_timer_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .word_addr(addr[ADDR_W-1:2]),
    .wr_stat  (wr_stat),
    .wr_ctrl  (wr_ctrl),
    .wr_per   (wr_per),
    .rd_hit   (rd_hit),
    .sel      (sel)
  );

  dcount_timer_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stat (wr_stat),
    .wr_ctrl (wr_ctrl),
    .wr_per  (wr_per),
    .wdata   (wdata),
    .expire  (expire),
    .ctrl_q  (ctrl_q),
    .period_q(period_q),
    .timeout (timeout),
    .irq     (irq)
  );

  dcount_timer_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_en      (wr_per),
    .ld_val     (wdata),
    .go         (wr_ctrl && wdata[CTL_GO]),
    .halt       (wr_ctrl && wdata[CTL_HALT]),
    .auto_reload(ctrl_q[CTL_AUTO]),
    .period     (period_q),
    .count      (count),
    .running    (running),
    .expire     (expire)
  );

  always_comb begin
    stat_word         = '0;
    stat_word[ST_TO]  = timeout;
    stat_word[ST_RUN] = running;
  end

  always_comb begin
    rdata = '0;
    if (rd_hit) begin
      case (sel)
        SEL_STAT: rdata = stat_word;
        SEL_CTRL: rdata = ctrl_q;
        SEL_PER:  rdata = period_q;
        default:  rdata = count;
      endcase
    end
  end
endmodule

// File: rtl/dcount_timer_chk.sv
module dcount_timer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stat,
  input logic              wr_ctrl,
  input logic              wr_per,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] period_q,
  input logic [DATA_W-1:0] count,
  input logic              running,
  input logic              expire,
  input logic              timeout,
  input logic              irq
);
  // R2: acknowledge clears the flag unless an expiry coincides
  a_r2_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat && !expire |=> !timeout);

  // R2 and R7: expiry always leaves the flag set
  a_r2_expiry_wins: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> timeout);

  // R3: stop bit halts, including when start is also set
  a_r3_halt_priority: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && wdata[3] |=> !running);

  // R3: start alone sets the counter running
  a_r3_go: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && wdata[2] && !wdata[3] |=> running);

  // R4: period write loads the live counter
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_per |=> count == $past(wdata));

  // R6: one-step decrement while running and non-zero
  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    running && count != '0 && !wr_per |=> count == $past(count) - 1'b1);

  // R7: one-shot expiry stops the counter
  a_r7_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !ctrl_q[1] && !wr_ctrl |=> !running);

  // R8: auto-reload refills from period and keeps running
  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    expire && ctrl_q[1] && !wr_per && !wr_ctrl |=> running && count == $past(period_q));

  // R9: no interrupt without a pending timeout
  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !timeout |-> !irq);
endmodule

bind dcount_timer dcount_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_stat (wr_stat),
  .wr_ctrl (wr_ctrl),
  .wr_per  (wr_per),
  .wdata   (wdata),
  .ctrl_q  (ctrl_q),
  .period_q(period_q),
  .count   (count),
  .running (running),
  .expire  (expire),
  .timeout (timeout),
  .irq     (irq)
);

// File: tb/dcount_timer_test.sv
`timescale 1ns/1ps
module dcount_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 1'b0;
  logic [31:0] v;

  localparam logic [4:0] A_ST = 5'h00, A_CT = 5'h04, A_PE = 5'h08, A_SN = 5'h0C;

  typedef struct packed {
    logic [31:0] per;
    logic [15:0] wait_c;
    logic [31:0] snap;
    logic [31:0] stat;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'd10,  16'd3,  32'd7,  32'h2},
    '{32'd5,   16'd5,  32'd0,  32'h1},
    '{32'd5,   16'd4,  32'd1,  32'h2},
    '{32'd0,   16'd0,  32'd0,  32'h1},
    '{32'd100, 16'd40, 32'd60, 32'h2},
    '{32'd3,   16'd20, 32'd0,  32'h1}
  };

  dcount_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // drives at a falling edge; takes effect at the next rising edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiesce();
    wr(A_CT, 32'h8);
    wr(A_ST, 32'h0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(A_ST, v); chk("R1 status", v, 32'h0);
    rd(A_CT, v); chk("R1 control", v, 32'h0);
    rd(A_PE, v); chk("R1 period", v, 32'h0);
    rd(A_SN, v); chk("R1 snapshot", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R10 unmapped and aliased addresses
    wr(5'h10, 32'h55);
    wr(5'h18, 32'h66);
    rd(5'h10, v); chk("R10 unmapped read", v, 32'h0);
    rd(A_CT, v);  chk("R10 unmapped write ignored (control)", v, 32'h0);
    rd(A_PE, v);  chk("R10 unmapped write ignored (period)", v, 32'h0);
    wr(5'h0B, 32'h77);
    rd(5'h09, v); chk("R10 low bits ignored", v, 32'h77);

    // R5 snapshot write ignored
    wr(A_PE, 32'd50);
    wr(A_SN, 32'd7);
    rd(A_SN, v); chk("R5 snapshot after write", v, 32'd50);
    rd(A_PE, v); chk("R5 period untouched", v, 32'd50);

    // R3 control readback
    wr(A_CT, 32'hA5A5_0003);
    rd(A_CT, v); chk("R3 control readback", v, 32'hA5A5_0003);
    wr(A_CT, 32'h0);

    // R6, R7, R11 table of one-shot runs
    for (int i = 0; i < NV; i++) begin
      quiesce();
      wr(A_PE, VECS[i].per);
      wr(A_CT, 32'h4);
      idle(int'(VECS[i].wait_c));
      rd(A_SN, v); chk($sformatf("R6 vec%0d snapshot", i), v, VECS[i].snap);
      rd(A_ST, v); chk($sformatf("R7 R11 vec%0d status", i), v, VECS[i].stat);
    end
    idle(3);
    rd(A_SN, v); chk("R7 stopped count stays 0", v, 32'h0);

    // R3 stop wins over start in the same word
    quiesce();
    wr(A_PE, 32'd30);
    wr(A_CT, 32'h4);
    wr(A_CT, 32'hC);
    rd(A_ST, v); chk("R3 stop priority status", v, 32'h0);
    rd(A_SN, v); chk("R3 count frozen a", v, 32'd29);
    rd(A_SN, v); chk("R3 count frozen b", v, 32'd29);
    rd(A_CT, v); chk("R3 control stored", v, 32'hC);

    // R2 status write: data ignored, running bit not writable, expiry wins
    quiesce();
    wr(A_ST, 32'h2);
    rd(A_ST, v); chk("R2 run bit not writable", v, 32'h0);
    wr(A_PE, 32'd2);
    wr(A_CT, 32'h4);
    idle(2);
    wr(A_ST, 32'hFFFF_FFFF);
    rd(A_ST, v); chk("R2 expiry beats clear", v, 32'h1);
    wr(A_ST, 32'h0);
    rd(A_ST, v); chk("R2 zero data clears", v, 32'h0);

    // R9 interrupt level
    quiesce();
    wr(A_PE, 32'd2);
    wr(A_CT, 32'h5);
    chk("R9 irq low before expiry", {31'b0, irq}, 32'h0);
    idle(3);
    chk("R9 irq after expiry", {31'b0, irq}, 32'h1);
    wr(A_CT, 32'h0);
    chk("R9 irq masked by enable", {31'b0, irq}, 32'h0);
    wr(A_CT, 32'h1);
    chk("R9 irq unmasked", {31'b0, irq}, 32'h1);
    wr(A_ST, 32'h0);
    chk("R9 irq dropped on ack", {31'b0, irq}, 32'h0);

    // R8 auto-reload
    quiesce();
    wr(A_PE, 32'd4);
    wr(A_CT, 32'h6);
    idle(6);
    rd(A_SN, v); chk("R8 reloaded count", v, 32'd3);
    rd(A_ST, v); chk("R8 status flag and running", v, 32'h3);

    // R4 period write into a running count
    quiesce();
    wr(A_PE, 32'd100);
    wr(A_CT, 32'h4);
    idle(5);
    wr(A_PE, 32'd20);
    rd(A_SN, v); chk("R4 loaded at once", v, 32'd20);
    rd(A_SN, v); chk("R4 continues from load", v, 32'd19);
    rd(A_PE, v); chk("R4 period stored", v, 32'd20);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule